// File: doc/BRIEF.md
# Rewindable Synchronous FIFO with Half-Full Status

This block is a single-clock first-in/first-out buffer for 9-bit words, one bit of which is free to carry parity or a control marker. Storage is addressed by two ring pointers that advance on their own, so the user never supplies an address. A write strobe carries a word in, and a read strobe pulls the oldest word out. Read data appears on a registered output one cycle later, marked by a one-cycle valid pulse. Both strobes may be raised in the same cycle.

Three status pins report whether the buffer is empty, whether it is full, and whether it holds more than half its capacity. These pins are the only back-pressure. A producer must not count on a write being taken while `full` is high, unless a read is accepted in that same cycle. A consumer gets no data from a read raised while `empty` is high. Strobes refused in this way are dropped: nothing is queued and no pointer moves.

A rewind input puts the read pointer back at storage location zero and leaves the write pointer alone. Everything written since reset can then be played out again, provided fewer than DEPTH words were written. This suits short frames that may need to be sent a second time.

Top module: `rewind_fifo`

## Requirements
- R1: While `rst_n` is low and after it rises, both pointers sit at location zero, `empty`=1, `full`=0, `half_full`=0, `rd_valid`=0 and `rd_data`=0.
- R2: Words come out in the order they were written, all WIDTH bits intact. `rd_data` and a one-cycle `rd_valid`=1 appear on the clock edge after the edge that accepts a read. In any cycle with no accepted read, `rd_valid`=0 and `rd_data` keeps its previous value.
- R3: With no reads after reset, `full` rises after exactly DEPTH writes and not before. A write while `full`=1 with no read in the same cycle is dropped: the stored contents and the write pointer do not change.
- R4: A read while `empty`=1 is dropped: no `rd_valid` pulse follows, `rd_data` holds, and the read pointer stays put.
- R5: `empty` is high exactly when the stored count is zero. It falls on the edge that accepts the first write into an empty buffer. `empty` and `full` are never high together.
- R6: `half_full` is high exactly when the stored count is greater than DEPTH/2. It rises on the write that takes the count to DEPTH/2+1 and falls on the read that brings the count back to DEPTH/2.
- R7: A rewind accepted alone sets the read pointer to location zero and keeps the write pointer. The count then becomes the write pointer's location index (0..DEPTH-1). If the buffer was full and that index is zero, the count stays DEPTH. All three flags follow the new count, and the next read returns the word stored at location zero.
- R8: `rewind` is ignored in any cycle where `wr_en` or `rd_en` is also high; that cycle behaves as if `rewind` were low.
- R9: Read and write raised together while `full`=1 are both accepted: the oldest word is returned, the new word is stored, and the count stays DEPTH. Raised together while `empty`=1, only the write takes effect.
- R10: Writes strobed while `rst_n` is low are not stored: the buffer is empty when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per word |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read strobe, one cycle per word |
| rd_data | output | WIDTH | Registered read data |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` carries a new word |
| rewind | input | 1 | Move the read pointer back to location zero |
| empty | output | 1 | No word stored |
| full | output | 1 | DEPTH words stored |
| half_full | output | 1 | More than DEPTH/2 words stored |

## Verification
The bench builds the block with DEPTH=8 and the default WIDTH=9. At this depth, filling the buffer, crossing the half-full boundary between four and five words, and wrapping the write pointer back to location zero each take only a few cycles. Both the rewind case with a partly filled buffer and the rewind case where a full buffer has wrapped exactly to location zero are therefore reached. Data values use bit 8 so that loss of the top bit is visible.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;

  // one cycle's worth of requests seen by the pointer logic
  typedef struct packed {
    logic wr;
    logic rd;
    logic rewind;
  } fifo_req_t;

  // decisions the pointer logic hands to storage
  typedef struct packed {
    logic wr_fire;
    logic rd_fire;
    logic rw_fire;
  } fifo_grant_t;

endpackage

// File: rtl/rfifo_ctrl.sv
module rfifo_ctrl
  import rfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fifo_req_t     req,
  output fifo_grant_t   grant,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic          is_full;
  logic          is_empty;
  logic [CW-1:0] count_nxt;
  logic [CW-1:0] rewind_cnt;

  always_comb begin
    is_full        = (count == CNT_FULL);
    is_empty       = (count == '0);
    grant.rd_fire  = req.rd && !is_empty;
    // a read accepted in the same cycle frees the slot the write needs
    grant.wr_fire  = req.wr && (!is_full || grant.rd_fire);
    grant.rw_fire  = req.rewind && !req.wr && !req.rd;
  end

  always_comb begin
    if ((wptr == '0) && is_full) rewind_cnt = CNT_FULL;
    else                         rewind_cnt = {1'b0, wptr};
  end

  always_comb begin
    count_nxt = count;
    if (grant.rw_fire) begin
      count_nxt = rewind_cnt;
    end else begin
      case ({grant.wr_fire, grant.rd_fire})
        2'b10:   count_nxt = count + 1'b1;
        2'b01:   count_nxt = count - 1'b1;
        default: count_nxt = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      count <= count_nxt;
      if (grant.wr_fire) wptr <= wptr + 1'b1;
      if (grant.rw_fire)      rptr <= '0;
      else if (grant.rd_fire) rptr <= rptr + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_FULL); // R3

  AST_FULL_HOLDS_WPTR: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && req.wr && !req.rd) |=> $stable(wptr)); // R3

  AST_EMPTY_HOLDS_RPTR: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && req.rd) |=> $stable(rptr)); // R4

  AST_REWIND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req.rewind && !req.wr && !req.rd) |=> (rptr == '0) && $stable(wptr)); // R7

  AST_REWIND_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req.rewind && req.wr && !req.rd) |=> $stable(rptr)); // R8

  AST_FULL_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && req.wr && req.rd && !req.rewind) |=> (count == CNT_FULL)); // R9

endmodule

// File: rtl/rfifo_store.sv
module rfifo_store
  import rfifo_pkg::*;
#(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fifo_grant_t      grant,
  input  logic [AW-1:0]    wptr,
  input  logic [AW-1:0]    rptr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (grant.wr_fire) mem[wptr] <= wr_data;
  end

  // read samples the old word even when a write hits the same slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= grant.rd_fire;
      if (grant.rd_fire) rd_data <= mem[rptr];
    end
  end

  AST_VALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    grant.rd_fire |=> rd_valid); // R2

  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !grant.rd_fire |=> (!rd_valid && $stable(rd_data))); // R2

endmodule

// File: rtl/rfifo_status.sv
module rfifo_status #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          half_full
);

  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_HALF = CW'(DEPTH / 2);

  always_comb begin
    empty     = (count == '0);
    full      = (count == CNT_FULL);
    half_full = (count > CNT_HALF);
  end

  AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full)); // R5

  AST_FULL_IS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> half_full); // R6

endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
  import rfifo_pkg::*;
#(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  input  logic             rewind,
  output logic             empty,
  output logic             full,
  output logic             half_full
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  fifo_req_t     req;
  fifo_grant_t   grant;
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic [CW-1:0] count;

  always_comb begin
    req.wr     = wr_enable_ok(wr_en);
    req.rd     = rd_en;
    req.rewind = rewind;
  end

  function automatic logic wr_enable_ok(input logic w);
    return w;
  endfunction

  rfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .grant (grant),
    .wptr  (wptr),
    .rptr  (rptr),
    .count (count)
  );

  rfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant    (grant),
    .wptr     (wptr),
    .rptr     (rptr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  rfifo_status #(.DEPTH(DEPTH)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .empty     (empty),
    .full      (full),
    .half_full (half_full)
  );

  AST_EMPTY_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en) |=> !rd_valid); // R4

endmodule

// File: tb/test_rewind_fifo.sv
module test_rewind_fifo;

  localparam int unsigned W = 9;
  localparam int unsigned D = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_en = 1'b0;
  logic         rewind = 1'b0;
  logic [W-1:0] rd_data;
  logic         rd_valid, empty, full, half_full;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rewind_fifo #(.WIDTH(W), .DEPTH(D)) i_rewind_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .rewind(rewind), .empty(empty), .full(full), .half_full(half_full)
  );

  // {wr, rd, rewind, wdata[8:0], exp empty, full, half, valid, exp rd_data[8:0]}
  localparam int NV = 12;
  localparam logic [24:0] VEC [NV] = '{
    {3'b100, 9'h101, 4'b0000, 9'h000}, // R5 first write clears empty
    {3'b100, 9'h0A2, 4'b0000, 9'h000},
    {3'b010, 9'h000, 4'b0001, 9'h101}, // R2 oldest first
    {3'b000, 9'h000, 4'b0000, 9'h101}, // R2 hold without read
    {3'b110, 9'h0B3, 4'b0001, 9'h0A2},
    {3'b010, 9'h000, 4'b1001, 9'h0B3}, // R5 empty again
    {3'b010, 9'h000, 4'b1000, 9'h0B3}, // R4 read on empty dropped
    {3'b110, 9'h1C4, 4'b0000, 9'h0B3}, // R9 empty: write only
    {3'b101, 9'h055, 4'b0000, 9'h0B3}, // R8 rewind with write ignored
    {3'b001, 9'h000, 4'b0010, 9'h0B3}, // R7 rewind: count 5, half
    {3'b010, 9'h000, 4'b0001, 9'h101}, // R7 replay from zero, R6 half drops
    {3'b010, 9'h000, 4'b0001, 9'h0A2}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic flags(input string tag, input logic e, input logic f, input logic h);
    chk(tag, {13'd0, empty, full, half_full}, {13'd0, e, f, h});
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic cyc(input logic w, input logic r, input logic rw, input logic [W-1:0] d);
    wr_en = w; rd_en = r; rewind = rw; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; rewind = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    // R10: write strobed during reset
    wr_en = 1'b1; wr_data = 9'h1AA;
    repeat (3) @(negedge clk);
    flags("R1 flags in reset", 1'b1, 1'b0, 1'b0);
    wr_en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    flags("R1 flags after reset", 1'b1, 1'b0, 1'b0);
    chk("R1 rd_valid/rd_data after reset", {6'd0, rd_valid, rd_data}, 16'd0);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R10 write in reset not stored", {15'd0, rd_valid}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      cyc(v[24], v[23], v[22], v[21:13]);
      chk($sformatf("R2/R4-R9 vector %0d flags+valid", i),
          {12'd0, empty, full, half_full, rd_valid}, {12'd0, v[12:9]});
      chk($sformatf("R2 vector %0d rd_data", i), {7'd0, rd_data}, {7'd0, v[8:0]});
    end

    // fill, boundary and full behaviour
    do_reset();
    for (int i = 0; i < D; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 9'(9'h100 + i));
      flags($sformatf("R3/R6 fill after %0d writes", i + 1),
            1'b0, (i + 1 == D), (i + 1 > D / 2));
    end
    cyc(1'b1, 1'b0, 1'b0, 9'h1FF);
    flags("R3 write while full dropped", 1'b0, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 1'b0, 9'h1EE);
    chk("R9 full read+write returns oldest", {6'd0, rd_valid, rd_data}, {7'd1, 9'h100});
    flags("R9 full read+write stays full", 1'b0, 1'b1, 1'b1);
    for (int i = 1; i <= D; i++) begin
      logic [W-1:0] e;
      e = (i == D) ? 9'h1EE : 9'(9'h100 + i);
      cyc(1'b0, 1'b1, 1'b0, '0);
      chk($sformatf("R2/R3 drain %0d", i), {6'd0, rd_valid, rd_data}, {6'd0, 1'b1, e});
      flags($sformatf("R5/R6 drain %0d flags", i), (i == D), 1'b0, (D - i > D / 2));
    end

    // rewind when a full buffer wrapped to location zero
    do_reset();
    for (int i = 0; i < D; i++) cyc(1'b1, 1'b0, 1'b0, 9'(9'h180 + i));
    cyc(1'b0, 1'b0, 1'b1, '0);
    flags("R7 rewind on wrapped full keeps full", 1'b0, 1'b1, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R7 replay after wrap", {6'd0, rd_valid, rd_data}, {7'd1, 9'h180});

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule